// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the serial slave side of a byte-addressed nonvolatile memory. A host drives a serial clock, a data line and an active-low select; the block recovers those pins with a system clock, decodes the first byte of each frame as a command and steers what follows. That can be a streaming read from the storage array, a run of write bytes handed to a page write buffer, a status byte returned or stored, or a one-byte request to arm or disarm writes. Frames use serial mode 0 (clock idles low) or mode 3 (clock idles high). Incoming bits are taken on the rising clock edge and outgoing bits change on the falling edge, most significant bit first.

Writes are not programmed here. The block reports each complete write byte with its address, and it raises a commit pulse when the select line goes high. The neighbouring status and protection logic decides whether a commit or a status write is honoured. An active-low pause input freezes a frame in the middle of a bit stream without losing its place. While the rest of the memory reports an internal write cycle in progress, only the status-read command is accepted.

Top module: `spi_mem_cmd`

## Requirements
- R1: After reset, and whenever the select is high, `spi_miso_oe` is 0 and none of the pulses `arr_rd_en`, `pb_wr_en`, `pb_commit`, `st_arm`, `st_disarm`, `st_wr_en` is raised.
- R2: The first 8 bits of a frame form the command code. The accepted codes are 0x06 (arm), 0x04 (disarm), 0x05 (status read), 0x01 (status write), 0x03 (array read) and 0x02 (array write). Any other code makes the rest of the frame produce no output enable and no pulse.
- R3: Arm (0x06) raises `st_arm` and disarm (0x04) raises `st_disarm`, once each, when the select rises, and only if the frame held exactly 8 bits. A frame with extra bits, even fewer than a byte, produces no pulse.
- R4: Array read (0x03) takes 16 address bits, MSB first, and keeps only the low AW bits (bit 15 is dropped with the default AW=15). Data comes out MSB first. The first bit appears after the falling clock edge that follows the last address bit.
- R5: A read streams without limit. The address goes up by one per byte and wraps from the top address (0x7FFF by default) to 0.
- R6: Array write (0x02) takes 16 address bits. Each complete data byte then raises `pb_wr_en` with `pb_wr_addr` and `pb_wr_data`. The address advances only inside an aligned page of 2^PAGE_BITS bytes (64 by default) and wraps to the start of that page.
- R7: `pb_commit` pulses when the select rises after an array write, but only if at least one full data byte arrived and no partial byte followed it.
- R8: Status read (0x05) shifts out `status_in` MSB first and repeats it for every further byte. It is accepted even while `busy` is high.
- R9: Status write (0x01) followed by exactly one data byte raises `st_wr_en` with that byte on `st_wr_data` when the select rises. Any other length produces no pulse.
- R10: While `busy` is high at the moment the command code completes, every code except 0x05 is ignored: no pulse and no output enable for that frame.
- R11: Pulling `spi_hold_n` low while the serial clock is low pauses the frame. `spi_miso_oe` drops, and clock and data activity are ignored. Releasing it while the clock is low resumes at the same bit.
- R12: Mode 3 frames (clock idle high) give the same results as mode 0 frames for write, read and status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the serial data output |
| busy | input | 1 | Internal write cycle in progress |
| status_in | input | 8 | Status byte supplied by the status block |
| arr_addr | output | AW | Read address for the storage array |
| arr_rd_en | output | 1 | Read strobe; data must be valid the next cycle and held until the next strobe |
| arr_rd_data | input | 8 | Array read data |
| pb_wr_en | output | 1 | One complete write byte for the page buffer |
| pb_wr_addr | output | AW | Address of that write byte |
| pb_wr_data | output | 8 | Write byte |
| pb_commit | output | 1 | Start programming of the loaded page |
| st_arm | output | 1 | Request to arm writes |
| st_disarm | output | 1 | Request to disarm writes |
| st_wr_en | output | 1 | Request to store a new status byte |
| st_wr_data | output | 8 | Status byte to store |

## Verification
The bench targets frames that stop at the wrong place: an arm with a few trailing bits, an arm followed by a full extra byte, and a write that ends partway through a byte. A design that counted only whole bytes, or looked only at the command code, would emit an arm pulse or a commit there. Address edges come next. A read starting at 0xFFFF must return the data at 0x7FFF and then at 0. A write starting two bytes before a page end must wrap to the page start. A design that kept bit 15 or carried into the page number would produce the wrong addresses. Pause is exercised in the middle of both the command code and a data byte while the clock keeps toggling, so a front end that counted those edges would return corrupt data. Busy frames check that a read stays silent while a status read still answers, and the same transfers are repeated with the clock idling high.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   localparam int BYTE_W    = 8;
   localparam int ADDR_IN_W = 16;

   localparam logic [BYTE_W-1:0] CODE_ARM     = 8'h06;
   localparam logic [BYTE_W-1:0] CODE_DISARM  = 8'h04;
   localparam logic [BYTE_W-1:0] CODE_STAT_RD = 8'h05;
   localparam logic [BYTE_W-1:0] CODE_STAT_WR = 8'h01;
   localparam logic [BYTE_W-1:0] CODE_READ    = 8'h03;
   localparam logic [BYTE_W-1:0] CODE_WRITE   = 8'h02;

   typedef enum logic [3:0] {
      PH_CODE,    // collecting command code
      PH_AHI,     // address high byte
      PH_ALO,     // address low byte
      PH_RDOUT,   // streaming array data
      PH_WRIN,    // collecting write bytes
      PH_STOUT,   // streaming status byte
      PH_STIN,    // collecting status byte
      PH_STFULL,  // status byte complete
      PH_ONEBYTE, // arm/disarm complete
      PH_DROP     // rest of frame ignored
   } phase_e;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 4,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold #(
   parameter bit HOLD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_act,
   input  logic sck_lvl,
   input  logic hold_n_lvl,
   output logic paused
);
   generate
      if (HOLD_EN) begin : g_hold
         // state may only change while the serial clock is low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        paused <= 1'b0;
            else if (!cs_act)  paused <= 1'b0;
            else if (!sck_lvl) paused <= !hold_n_lvl;
         end

         p_pause_clk_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(paused) |-> !$past(sck_lvl));
         p_resume_clk_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(paused) && $past(cs_act)) |-> !$past(sck_lvl));
      end else begin : g_nohold
         assign paused = 1'b0;
         logic unused_hold;
         assign unused_hold = ^{clk, rst_n, cs_act, sck_lvl, hold_n_lvl};
      end
   endgenerate
endmodule

// File: rtl/spi_fe_txsh.sv
module spi_fe_txsh
   import spi_fe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              shift,
   input  logic [BYTE_W-1:0] din,
   output logic              dout
);
   logic [BYTE_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         dout <= 1'b0;
      end else if (clr) begin
         sr   <= '0;
         dout <= 1'b0;
      end else if (load) begin
         dout <= din[BYTE_W-1];
         sr   <= {din[BYTE_W-2:0], 1'b0};
      end else if (shift) begin
         dout <= sr[BYTE_W-1];
         sr   <= {sr[BYTE_W-2:0], 1'b0};
      end
   end

   p_load_shift_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
   import spi_fe_pkg::*;
#(
   parameter int AW          = 15,
   parameter int PAGE_BITS   = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit HOLD_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_sck,
   input  logic          spi_cs_n,
   input  logic          spi_mosi,
   input  logic          spi_hold_n,
   output logic          spi_miso,
   output logic          spi_miso_oe,
   input  logic          busy,
   input  logic [7:0]    status_in,
   output logic [AW-1:0] arr_addr,
   output logic          arr_rd_en,
   input  logic [7:0]    arr_rd_data,
   output logic          pb_wr_en,
   output logic [AW-1:0] pb_wr_addr,
   output logic [7:0]    pb_wr_data,
   output logic          pb_commit,
   output logic          st_arm,
   output logic          st_disarm,
   output logic          st_wr_en,
   output logic [7:0]    st_wr_data
);
   localparam int          BIT_W = $clog2(BYTE_W);
   localparam logic [AW-1:0] PMASK = AW'((32'd1 << PAGE_BITS) - 32'd1);
   localparam logic [3:0]  PIN_RST = 4'b1100; // cs_n, hold_n high; sck, mosi low

   generate
      if (AW < 1 || AW > ADDR_IN_W) begin : g_bad_aw
         $error("AW must lie in 1..16");
      end
      if (PAGE_BITS < 1 || PAGE_BITS > AW) begin : g_bad_page
         $error("PAGE_BITS must lie in 1..AW");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- pin recovery ----------------
   logic [3:0] pins_s;
   logic cs_n_s, hold_n_s, sck_s, mosi_s;

   spi_fe_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_hold_n, spi_sck, spi_mosi}),
      .q     (pins_s)
   );
   assign {cs_n_s, hold_n_s, sck_s, mosi_s} = pins_s;

   logic cs_act, cs_q, sck_q, paused;
   assign cs_act = !cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_act;
      end
   end

   spi_fe_hold #(.HOLD_EN(HOLD_EN)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .sck_lvl    (sck_s),
      .hold_n_lvl (hold_n_s),
      .paused     (paused)
   );

   logic rise, fall, frame_end;
   assign rise      = cs_act && !paused &&  sck_s && !sck_q;
   assign fall      = cs_act && !paused && !sck_s &&  sck_q;
   assign frame_end = cs_q && !cs_act;

   // ---------------- frame state ----------------
   phase_e             phase;
   logic [BIT_W-1:0]   bit_cnt;
   logic [BYTE_W-1:0]  rx_sr;
   logic [BYTE_W-1:0]  addr_hi;
   logic [AW-1:0]      ptr;
   logic               is_read, is_arm, wrote_any, tx_on, rd_go;

   logic [BYTE_W-1:0]    byte_in;
   logic                 byte_done;
   logic [ADDR_IN_W-1:0] addr_full;
   logic [AW-1:0]        ptr_page_next;
   logic                 out_phase, tx_load, tx_shift;

   assign byte_in       = {rx_sr[BYTE_W-2:0], mosi_s};
   assign byte_done     = rise && (bit_cnt == BIT_W'(BYTE_W-1));
   assign addr_full     = {addr_hi, byte_in};
   assign ptr_page_next = (ptr & ~PMASK) | ((ptr + AW'(1)) & PMASK);
   assign out_phase     = (phase == PH_RDOUT) || (phase == PH_STOUT);
   assign tx_load       = fall && out_phase && (bit_cnt == '0);
   assign tx_shift      = fall && out_phase && (bit_cnt != '0) && tx_on;

   logic unused_bits;
   assign unused_bits = ^{addr_full, rx_sr[BYTE_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_CODE;
         bit_cnt    <= '0;
         rx_sr      <= '0;
         addr_hi    <= '0;
         ptr        <= '0;
         is_read    <= 1'b0;
         is_arm     <= 1'b0;
         wrote_any  <= 1'b0;
         tx_on      <= 1'b0;
         rd_go      <= 1'b0;
         pb_wr_en   <= 1'b0;
         pb_wr_addr <= '0;
         pb_wr_data <= '0;
         pb_commit  <= 1'b0;
         st_arm     <= 1'b0;
         st_disarm  <= 1'b0;
         st_wr_en   <= 1'b0;
         st_wr_data <= '0;
      end else begin
         rd_go     <= 1'b0;
         pb_wr_en  <= 1'b0;
         pb_commit <= 1'b0;
         st_arm    <= 1'b0;
         st_disarm <= 1'b0;
         st_wr_en  <= 1'b0;

         if (frame_end && bit_cnt == '0) begin
            unique case (phase)
               PH_ONEBYTE: begin
                  st_arm    <=  is_arm;
                  st_disarm <= !is_arm;
               end
               PH_STFULL: st_wr_en  <= 1'b1;
               PH_WRIN:   pb_commit <= wrote_any;
               default: ;
            endcase
         end

         if (!cs_act) begin
            phase     <= PH_CODE;
            bit_cnt   <= '0;
            tx_on     <= 1'b0;
            wrote_any <= 1'b0;
         end else begin
            if (rise) begin
               rx_sr   <= byte_in;
               bit_cnt <= bit_cnt + BIT_W'(1);
               unique case (phase)
                  PH_CODE: if (byte_done) begin
                     if (busy && byte_in != CODE_STAT_RD) begin
                        phase <= PH_DROP;
                     end else begin
                        unique case (byte_in)
                           CODE_ARM:     begin phase <= PH_ONEBYTE; is_arm <= 1'b1; end
                           CODE_DISARM:  begin phase <= PH_ONEBYTE; is_arm <= 1'b0; end
                           CODE_STAT_RD: phase <= PH_STOUT;
                           CODE_STAT_WR: phase <= PH_STIN;
                           CODE_READ:    begin phase <= PH_AHI; is_read <= 1'b1; end
                           CODE_WRITE:   begin phase <= PH_AHI; is_read <= 1'b0; end
                           default:      phase <= PH_DROP;
                        endcase
                     end
                  end
                  PH_AHI: if (byte_done) begin
                     addr_hi <= byte_in;
                     phase   <= PH_ALO;
                  end
                  PH_ALO: if (byte_done) begin
                     ptr <= addr_full[AW-1:0];
                     if (is_read) begin
                        phase <= PH_RDOUT;
                        rd_go <= 1'b1;
                     end else begin
                        phase <= PH_WRIN;
                     end
                  end
                  PH_WRIN: if (byte_done) begin
                     pb_wr_en   <= 1'b1;
                     pb_wr_addr <= ptr;
                     pb_wr_data <= byte_in;
                     ptr        <= ptr_page_next;
                     wrote_any  <= 1'b1;
                  end
                  PH_STIN: if (byte_done) begin
                     st_wr_data <= byte_in;
                     phase      <= PH_STFULL;
                  end
                  PH_STFULL, PH_ONEBYTE: phase <= PH_DROP;
                  default: ;
               endcase
            end
            if (tx_load) begin
               tx_on <= 1'b1;
               if (phase == PH_RDOUT) begin
                  ptr   <= ptr + AW'(1);
                  rd_go <= 1'b1;
               end
            end
         end
      end
   end

   // ---------------- output path ----------------
   spi_fe_txsh u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!cs_act),
      .load  (tx_load),
      .shift (tx_shift),
      .din   ((phase == PH_RDOUT) ? arr_rd_data : status_in),
      .dout  (spi_miso)
   );

   assign spi_miso_oe = tx_on && cs_act && !paused;
   assign arr_addr    = ptr;
   assign arr_rd_en   = rd_go;

   // ---------------- checks ----------------
   p_oe_in_output_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_miso_oe |-> out_phase);
   p_frame_pulses_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_arm, st_disarm, pb_commit, st_wr_en}));
   p_wr_byte_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pb_wr_en |-> (phase == PH_WRIN));
   p_pause_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && $past(paused) && $past(cs_act)) |-> ($stable(bit_cnt) && $stable(phase)));
   p_busy_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_CODE && busy && byte_in != CODE_STAT_RD) |=> (phase == PH_DROP));
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!cs_act) && !cs_act) |-> !(spi_miso_oe || arr_rd_en || pb_wr_en));
endmodule

// File: tb/sim_spi_mem_cmd.sv
module sim_spi_mem_cmd;
   localparam int AW   = 15;
   localparam int HALF = 8;
   localparam int K_WR = 1, K_CM = 2, K_ARM = 3, K_DIS = 4, K_STW = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, spi_sck, spi_cs_n, spi_mosi, spi_hold_n, busy;
   logic [7:0] status_in, rdat;
   logic spi_miso, spi_miso_oe, arr_rd_en, pb_wr_en, pb_commit, st_arm, st_disarm, st_wr_en;
   logic [AW-1:0] arr_addr, pb_wr_addr;
   logic [7:0] pb_wr_data, st_wr_data;

   spi_mem_cmd u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .spi_miso(spi_miso),
      .spi_miso_oe(spi_miso_oe), .busy(busy), .status_in(status_in),
      .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .arr_rd_data(rdat),
      .pb_wr_en(pb_wr_en), .pb_wr_addr(pb_wr_addr), .pb_wr_data(pb_wr_data),
      .pb_commit(pb_commit), .st_arm(st_arm), .st_disarm(st_disarm),
      .st_wr_en(st_wr_en), .st_wr_data(st_wr_data)
   );

   function automatic logic [7:0] f(input logic [AW-1:0] a);
      return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h5A;
   endfunction

   always @(posedge clk) if (arr_rd_en) rdat <= f(arr_addr);

   int total = 0, bad = 0;
   bit mode3 = 1'b0, oe_seen = 1'b0;

   typedef struct { int k; int a; int d; string rq; } ev_t;
   ev_t exp_q[$];

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   task automatic expect_ev(input int k, input int a, input int d, input string rq);
      ev_t e;
      e.k = k; e.a = a; e.d = d; e.rq = rq;
      exp_q.push_back(e);
   endtask

   task automatic take(input int k, input int a, input int d);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R1/R2/R3", "unexpected event", k, 0);
      end else begin
         e = exp_q.pop_front();
         chk(e.k == k && e.a == a && e.d == d, e.rq, "event kind/addr/data",
             (k << 24) | (a << 8) | d, (e.k << 24) | (e.a << 8) | e.d);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_miso_oe) oe_seen = 1'b1;
         if (pb_wr_en)  take(K_WR, int'(pb_wr_addr), int'(pb_wr_data));
         if (pb_commit) take(K_CM, 0, 0);
         if (st_arm)    take(K_ARM, 0, 0);
         if (st_disarm) take(K_DIS, 0, 0);
         if (st_wr_en)  take(K_STW, 0, int'(st_wr_data));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bits(input logic [7:0] v, input int n, output logic [7:0] r);
      r = '0;
      for (int i = 0; i < n; i++) begin
         if (mode3) spi_sck = 1'b0;
         spi_mosi = v[7-i];
         tick(HALF);
         r = {r[6:0], spi_miso};
         spi_sck = 1'b1;
         tick(HALF);
         if (!mode3) spi_sck = 1'b0;
      end
   endtask

   task automatic xb(input logic [7:0] v, output logic [7:0] r);
      bits(v, 8, r);
   endtask

   task automatic fstart();
      oe_seen = 1'b0;
      spi_cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic fend();
      tick(HALF);
      spi_cs_n = 1'b1;
      tick(12);
   endtask

   task automatic q_empty(input string rq);
      chk(exp_q.size() == 0, rq, "pending expected events", exp_q.size(), 0);
   endtask

   task automatic do_read(input logic [15:0] a16, input int n, input string rq);
      logic [7:0] r;
      logic [AW-1:0] a;
      a = a16[AW-1:0];
      fstart();
      xb(8'h03, r); xb(a16[15:8], r); xb(a16[7:0], r);
      for (int k = 0; k < n; k++) begin
         xb(8'h00, r);
         chk(r == f(a), rq, "read byte", r, f(a));
         a = a + 1'b1;
      end
      fend();
      chk(oe_seen, rq, "output enabled during read", oe_seen, 1);
   endtask

   task automatic do_write(input logic [15:0] a16, input int n, input logic [7:0] seed, input string rq);
      logic [7:0] r;
      logic [AW-1:0] a;
      a = a16[AW-1:0];
      fstart();
      xb(8'h02, r); xb(a16[15:8], r); xb(a16[7:0], r);
      for (int k = 0; k < n; k++) begin
         expect_ev(K_WR, int'(a), int'(seed + 8'(k)), rq);
         xb(seed + 8'(k), r);
         a = {a[AW-1:6], a[5:0] + 6'd1};
      end
      expect_ev(K_CM, 0, 0, "R7");
      fend();
      q_empty(rq);
   endtask

   task automatic pause_here(input string rq);
      spi_mosi = 1'b1;
      spi_hold_n = 1'b0;
      tick(HALF);
      oe_seen = 1'b0;
      repeat (3) begin
         spi_sck = 1'b1; tick(HALF);
         spi_sck = 1'b0; tick(HALF);
      end
      chk(!oe_seen, rq, "output enable during pause", oe_seen, 0);
      spi_hold_n = 1'b1;
      tick(HALF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] r, r1, r2;
      rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
      spi_hold_n = 1'b1; busy = 1'b0; status_in = 8'h3C; rdat = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(10);
      chk(!spi_miso_oe, "R1", "oe after reset", spi_miso_oe, 0);
      chk(!arr_rd_en, "R1", "read strobe after reset", arr_rd_en, 0);

      // R3 arm and disarm
      fstart(); expect_ev(K_ARM, 0, 0, "R3"); xb(8'h06, r); fend(); q_empty("R3");
      fstart(); expect_ev(K_DIS, 0, 0, "R3"); xb(8'h04, r); fend(); q_empty("R3");
      // R3 trailing partial byte cancels
      fstart(); xb(8'h06, r); bits(8'h00, 3, r); fend(); q_empty("R3");
      chk(!oe_seen, "R3", "oe in partial arm", oe_seen, 0);
      // R3 trailing full byte cancels
      fstart(); xb(8'h06, r); xb(8'h00, r); fend(); q_empty("R3");

      // R2 unknown code
      fstart(); xb(8'hA5, r); xb(8'h00, r); xb(8'h00, r); fend();
      q_empty("R2");
      chk(!oe_seen, "R2", "oe after unknown code", oe_seen, 0);

      // R4 read, R5 wrap with top bit dropped
      do_read(16'h0123, 3, "R4");
      do_read(16'hFFFF, 2, "R5");

      // R6 page wrap and R7 commit
      do_write(16'h013E, 3, 8'hA0, "R6");
      // R7 partial byte after data: byte reported, no commit
      fstart(); xb(8'h02, r); xb(8'h00, r); xb(8'h10, r);
      expect_ev(K_WR, 16'h0010, 8'h77, "R7");
      xb(8'h77, r); bits(8'hFF, 3, r); fend(); q_empty("R7");

      // R9 status write
      fstart(); expect_ev(K_STW, 0, 8'h8C, "R9"); xb(8'h01, r); xb(8'h8C, r); fend(); q_empty("R9");
      fstart(); xb(8'h01, r); xb(8'h8C, r); bits(8'h00, 2, r); fend(); q_empty("R9");

      // R8 status read repeats
      fstart(); xb(8'h05, r); xb(8'h00, r1); xb(8'h00, r2); fend();
      chk(r1 == 8'h3C, "R8", "status byte 1", r1, 8'h3C);
      chk(r2 == 8'h3C, "R8", "status byte 2", r2, 8'h3C);

      // R10 busy
      busy = 1'b1; status_in = 8'hC1;
      fstart(); xb(8'h06, r); fend(); q_empty("R10");
      fstart(); xb(8'h03, r); xb(8'h00, r); xb(8'h10, r); xb(8'h00, r); fend();
      chk(!oe_seen, "R10", "oe for read while busy", oe_seen, 0);
      fstart(); xb(8'h05, r); xb(8'h00, r1); fend();
      chk(r1 == 8'hC1, "R10", "status read while busy", r1, 8'hC1);
      busy = 1'b0; status_in = 8'h3C;

      // R11 pause inside code and inside data byte
      fstart();
      bits(8'h03, 4, r); pause_here("R11"); bits(8'h30, 4, r);
      xb(8'h02, r); xb(8'h00, r);
      xb(8'h00, r1);
      chk(r1 == f(15'h0200), "R11", "byte before pause", r1, f(15'h0200));
      bits(8'h00, 3, r1); pause_here("R11"); bits(8'h00, 5, r2);
      chk({r1[2:0], r2[4:0]} == f(15'h0201), "R11", "byte across pause",
          {r1[2:0], r2[4:0]}, f(15'h0201));
      fend();

      // R12 clock idles high
      mode3 = 1'b1; spi_sck = 1'b1; tick(8);
      do_write(16'h0040, 2, 8'h11, "R12");
      do_read(16'h7FFE, 3, "R12");
      fstart(); xb(8'h05, r); xb(8'h00, r1); fend();
      chk(r1 == 8'h3C, "R12", "status read mode 3", r1, 8'h3C);

      tick(20);
      q_empty("R1");
      chk(!spi_miso_oe, "R1", "oe idle at end", spi_miso_oe, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule